// File: doc/BRIEF.md
# Capture Port Clock Controller

This block owns the bit clock and the left/right frame clock of an audio capture serial port. When the port is the clock master, it divides an incoming master clock down to a 64-slot bit clock and a 50 % duty frame clock. When the port is a clock slave, it turns off its drivers so that both pins act as inputs. The master/slave choice is the OR of an external strap pin and a register bit. A power-down pin overrides both. While power-down is active, a high strap pin keeps the pins driven low instead of releasing them.

A second part decides when the converter may run. It watches the master clock and the incoming frame clock from a faster reference clock. It raises a converter-active flag only when three things hold: the power-down pin is released, the converter power and core run register bits are set, and the clocks it needs have been seen. The master clock ratio (256, 384, 512 or 768 times the sample rate) can be changed on the fly. A change is applied only at the next frame clock transition.

The converter-active flag comes from a four-state machine clocked by the reference clock:
- `CV_OFF` goes to `CV_WAIT_MCLK` when the power and run bits are both set.
- `CV_WAIT_MCLK` goes to `CV_ACTIVE` once the master clock is present in master mode. In slave mode it goes to `CV_WAIT_FRAME` instead.
- `CV_WAIT_FRAME` goes to `CV_ACTIVE` once the frame clock is present or master mode is chosen. It goes back to `CV_WAIT_MCLK` if the master clock is lost.
- `CV_ACTIVE` goes to `CV_WAIT_MCLK` on master clock loss. In slave mode it goes to `CV_WAIT_FRAME` on frame clock loss.
- Any state goes to `CV_OFF` when the power or run bit is cleared.
- Power-down forces `CV_OFF` asynchronously.

The pin decoder has four modes: `PIN_RELEASED`, `PIN_HELD_LOW`, `PIN_SLAVE` and `PIN_MASTER`.

Top module: `adc_port_clkctl`

## Requirements
- R1: With `pdn_n`=1, both output enables are 1 when `mode_pin` or `mode_bit` is 1, and both are 0 when both are 0.
- R2: With `pdn_n`=0 and `mode_pin`=0, both output enables are 0 whatever `mode_bit` holds.
- R3: With `pdn_n`=0 and `mode_pin`=1, both output enables are 1 and `bclk_o` and `lrclk_o` stay 0.
- R4: In master mode, `ratio_sel` encodes the `bclk_o` period in master clock cycles: 2'b00 gives 4 (256 fs), 2'b01 gives 6 (384 fs), 2'b10 gives 8 (512 fs), 2'b11 gives 12 (768 fs).
- R5: The `lrclk_o` period is 64 `bclk_o` periods, and `lrclk_o` is high for exactly 32 of them.
- R6: `lrclk_o` changes only on the master clock edge on which `bclk_o` falls from 1 to 0.
- R7: A new `ratio_sel` value does not alter `bclk_o` periods before the next `lrclk_o` transition. It applies from that transition on.
- R8: `conv_active` is 0 while `pdn_n`=0, and goes to 0 within one reference clock cycle when `conv_pwr`=0 or `core_run`=0.
- R9: In master mode, `conv_active` rises once the master clock toggles, with no frame clock input needed.
- R10: In slave mode, `conv_active` stays 0 until `lrclk_i` toggles as well as the master clock.
- R11: A monitored clock with no edge for `TIMEOUT_CYC` reference cycles is declared missing and `conv_active` drops. It stays high before that limit is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock feeding the dividers |
| ref_clk | input | 1 | Reference clock for clock detection and the converter state machine |
| pdn_n | input | 1 | Power-down pin, active low, asynchronous |
| mode_pin | input | 1 | Master request strap pin |
| mode_bit | input | 1 | Master request register bit |
| ratio_sel | input | 2 | Master clock ratio field |
| conv_pwr | input | 1 | Converter power register bit |
| core_run | input | 1 | Core reset register bit, 0 holds reset |
| lrclk_i | input | 1 | Frame clock pin input used in slave mode |
| bclk_o | output | 1 | Bit clock drive value |
| bclk_oe | output | 1 | Bit clock output enable |
| lrclk_o | output | 1 | Frame clock drive value |
| lrclk_oe | output | 1 | Frame clock output enable |
| conv_active | output | 1 | Converter may run |

## Verification
The bench keeps the default `BCLK_PER_FRAME` of 64, so the measured periods are the full-size dividers of 4, 6, 8 and 12, including both non-power-of-two ratios. `TIMEOUT_CYC` stays at 2048 with a 4 ns reference against a 10 ns master clock. With these values a stopped master clock can be checked on both sides of the timeout edge within a short run. A 500 ns half-period slave frame clock is also detected well inside the limit.

// File: rtl/ckc_pkg.sv
package ckc_pkg;

    typedef enum logic [1:0] {
        PIN_RELEASED,
        PIN_HELD_LOW,
        PIN_SLAVE,
        PIN_MASTER
    } pin_mode_e;

    typedef enum logic [1:0] {
        CV_OFF,
        CV_WAIT_MCLK,
        CV_WAIT_FRAME,
        CV_ACTIVE
    } conv_state_e;

    // master clock cycles per sample for each ratio code
    function automatic int unsigned fs_ratio(input logic [1:0] sel);
        case (sel)
            2'b00:   return 256;
            2'b01:   return 384;
            2'b10:   return 512;
            default: return 768;
        endcase
    endfunction

endpackage

// File: rtl/ckc_pin_mode.sv
module ckc_pin_mode
    import ckc_pkg::*;
(
    input  logic pdn_n,
    input  logic mode_pin,
    input  logic mode_bit,
    output logic drive_en,
    output logic run
);

    pin_mode_e mode;

    always_comb begin
        if (!pdn_n)
            mode = mode_pin ? PIN_HELD_LOW : PIN_RELEASED;
        else
            mode = (mode_pin | mode_bit) ? PIN_MASTER : PIN_SLAVE;
    end

    always_comb begin
        drive_en = 1'b0;
        run      = 1'b0;
        unique case (mode)
            PIN_RELEASED: ;
            PIN_HELD_LOW: drive_en = 1'b1;
            PIN_SLAVE:    ;
            PIN_MASTER: begin
                drive_en = 1'b1;
                run      = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ckc_divider.sv
module ckc_divider
    import ckc_pkg::*;
#(
    parameter int unsigned BCLK_PER_FRAME = 64
) (
    input  logic       mclk,
    input  logic       pdn_n,
    input  logic       run,
    input  logic [1:0] ratio_sel,
    output logic       bclk,
    output logic       lrclk,
    output logic [1:0] ratio_act,
    output logic       started
);

    localparam int unsigned MAX_HALF = fs_ratio(2'b11) / BCLK_PER_FRAME / 2;
    localparam int unsigned HALF_W   = $clog2(MAX_HALF + 1);
    localparam int unsigned LR_HALF  = BCLK_PER_FRAME / 2;
    localparam int unsigned LR_W     = $clog2(LR_HALF);

    logic [HALF_W-1:0] phase;
    logic [HALF_W-1:0] half;
    logic [LR_W-1:0]   slots;
    logic              flip;

    // half bit clock period in master clock cycles
    assign half = HALF_W'(fs_ratio(ratio_act) / BCLK_PER_FRAME / 2);
    assign flip = (phase == half - HALF_W'(1));

    always_ff @(posedge mclk or negedge pdn_n) begin
        if (!pdn_n) begin
            started   <= 1'b0;
            phase     <= '0;
            slots     <= '0;
            bclk      <= 1'b0;
            lrclk     <= 1'b0;
            ratio_act <= 2'b00;
        end else if (!run || !started) begin
            started   <= run;
            phase     <= '0;
            slots     <= '0;
            bclk      <= 1'b0;
            lrclk     <= 1'b0;
            ratio_act <= ratio_sel;
        end else if (flip) begin
            phase <= '0;
            bclk  <= ~bclk;
            if (bclk) begin
                if (slots == LR_W'(LR_HALF - 1)) begin
                    slots     <= '0;
                    lrclk     <= ~lrclk;
                    ratio_act <= ratio_sel;
                end else begin
                    slots <= slots + 1'b1;
                end
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/ckc_presence.sv
module ckc_presence #(
    parameter int unsigned TIMEOUT_CYC = 2048
) (
    input  logic ref_clk,
    input  logic pdn_n,
    input  logic mon,
    output logic present
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic [2:0]       smp;
    logic [CNT_W-1:0] idle;
    logic             toggled;

    assign toggled = smp[2] ^ smp[1];

    always_ff @(posedge ref_clk or negedge pdn_n) begin
        if (!pdn_n) smp <= '0;
        else        smp <= {smp[1:0], mon};
    end

    always_ff @(posedge ref_clk or negedge pdn_n) begin
        if (!pdn_n) begin
            idle    <= '0;
            present <= 1'b0;
        end else if (toggled) begin
            idle    <= '0;
            present <= 1'b1;
        end else if (idle == CNT_W'(TIMEOUT_CYC - 1)) begin
            present <= 1'b0;
        end else begin
            idle <= idle + 1'b1;
        end
    end

endmodule

// File: rtl/ckc_conv_fsm.sv
module ckc_conv_fsm
    import ckc_pkg::*;
(
    input  logic ref_clk,
    input  logic pdn_n,
    input  logic conv_pwr,
    input  logic core_run,
    input  logic master,
    input  logic mclk_ok,
    input  logic frame_ok,
    output logic conv_active
);

    conv_state_e state;
    conv_state_e nxt;

    always_ff @(posedge ref_clk or negedge pdn_n) begin
        if (!pdn_n) state <= CV_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!conv_pwr || !core_run) begin
            nxt = CV_OFF;
        end else begin
            unique case (state)
                CV_OFF:        nxt = CV_WAIT_MCLK;
                CV_WAIT_MCLK:  if (mclk_ok) nxt = master ? CV_ACTIVE : CV_WAIT_FRAME;
                CV_WAIT_FRAME: if (!mclk_ok) nxt = CV_WAIT_MCLK;
                               else if (master || frame_ok) nxt = CV_ACTIVE;
                CV_ACTIVE:     if (!mclk_ok) nxt = CV_WAIT_MCLK;
                               else if (!master && !frame_ok) nxt = CV_WAIT_FRAME;
            endcase
        end
    end

    always_comb conv_active = (state == CV_ACTIVE);

endmodule

// File: rtl/adc_port_clkctl.sv
module adc_port_clkctl #(
    parameter int unsigned BCLK_PER_FRAME = 64,
    parameter int unsigned TIMEOUT_CYC    = 2048
) (
    input  logic       mclk,
    input  logic       ref_clk,
    input  logic       pdn_n,
    input  logic       mode_pin,
    input  logic       mode_bit,
    input  logic [1:0] ratio_sel,
    input  logic       conv_pwr,
    input  logic       core_run,
    input  logic       lrclk_i,
    output logic       bclk_o,
    output logic       bclk_oe,
    output logic       lrclk_o,
    output logic       lrclk_oe,
    output logic       conv_active
);

    localparam int unsigned N_MON = 2;

    logic             drive_en;
    logic             run;
    logic [1:0]       ratio_act;
    logic             div_started;
    logic [N_MON-1:0] mon_vec;
    logic [N_MON-1:0] seen;
    logic             mclk_ok;
    logic             frame_ok;

    ckc_pin_mode u_pins (
        .pdn_n    (pdn_n),
        .mode_pin (mode_pin),
        .mode_bit (mode_bit),
        .drive_en (drive_en),
        .run      (run)
    );

    ckc_divider #(.BCLK_PER_FRAME(BCLK_PER_FRAME)) u_div (
        .mclk      (mclk),
        .pdn_n     (pdn_n),
        .run       (run),
        .ratio_sel (ratio_sel),
        .bclk      (bclk_o),
        .lrclk     (lrclk_o),
        .ratio_act (ratio_act),
        .started   (div_started)
    );

    assign bclk_oe  = drive_en;
    assign lrclk_oe = drive_en;

    // index 0 watches the master clock, index 1 the slave frame clock
    assign mon_vec = {lrclk_i, mclk};

    for (genvar g = 0; g < N_MON; g++) begin : g_mon
        ckc_presence #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
            .ref_clk (ref_clk),
            .pdn_n   (pdn_n),
            .mon     (mon_vec[g]),
            .present (seen[g])
        );
    end

    assign mclk_ok  = seen[0];
    assign frame_ok = seen[1];

    ckc_conv_fsm u_fsm (
        .ref_clk     (ref_clk),
        .pdn_n       (pdn_n),
        .conv_pwr    (conv_pwr),
        .core_run    (core_run),
        .master      (mode_pin | mode_bit),
        .mclk_ok     (mclk_ok),
        .frame_ok    (frame_ok),
        .conv_active (conv_active)
    );

endmodule

// File: rtl/ckc_checker.sv
module ckc_checker (
    input logic       mclk,
    input logic       ref_clk,
    input logic       pdn_n,
    input logic       mode_pin,
    input logic       master,
    input logic       conv_pwr,
    input logic       core_run,
    input logic       bclk_o,
    input logic       bclk_oe,
    input logic       lrclk_o,
    input logic       lrclk_oe,
    input logic       conv_active,
    input logic       mclk_ok,
    input logic       frame_ok,
    input logic [1:0] ratio_act,
    input logic       started
);

    logic armed;

    always_ff @(posedge mclk or negedge pdn_n) begin
        if (!pdn_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: released pins in power-down without strap
    always @(negedge ref_clk) begin
        if (!pdn_n && !mode_pin)
            p_pd_released_r2: assert (!bclk_oe && !lrclk_oe);
    end

    // R3: strapped master in power-down holds both pins low
    always @(negedge ref_clk) begin
        if (!pdn_n && mode_pin)
            p_pd_held_low_r3: assert (bclk_oe && lrclk_oe && !bclk_o && !lrclk_o);
    end

    p_lr_on_bclk_fall_r6: assert property (@(posedge mclk) disable iff (!pdn_n)
        (armed && (lrclk_o != $past(lrclk_o))) |-> ($past(bclk_o) && !bclk_o));

    p_ratio_at_frame_r7: assert property (@(posedge mclk) disable iff (!pdn_n)
        (armed && started && $past(started) && (ratio_act != $past(ratio_act)))
        |-> (lrclk_o != $past(lrclk_o)));

    p_gate_off_r8: assert property (@(posedge ref_clk) disable iff (!pdn_n)
        (!conv_pwr || !core_run) |=> !conv_active);

    p_slave_frame_r10: assert property (@(posedge ref_clk) disable iff (!pdn_n)
        (!master && !frame_ok) |=> !conv_active);

    p_mclk_lost_r11: assert property (@(posedge ref_clk) disable iff (!pdn_n)
        !mclk_ok |=> !conv_active);

endmodule

bind adc_port_clkctl ckc_checker u_chk (
    .mclk        (mclk),
    .ref_clk     (ref_clk),
    .pdn_n       (pdn_n),
    .mode_pin    (mode_pin),
    .master      (mode_pin | mode_bit),
    .conv_pwr    (conv_pwr),
    .core_run    (core_run),
    .bclk_o      (bclk_o),
    .bclk_oe     (bclk_oe),
    .lrclk_o     (lrclk_o),
    .lrclk_oe    (lrclk_oe),
    .conv_active (conv_active),
    .mclk_ok     (mclk_ok),
    .frame_ok    (frame_ok),
    .ratio_act   (ratio_act),
    .started     (div_started)
);

// File: tb/adc_port_clkctl_test.sv
`timescale 1ns/1ps
module adc_port_clkctl_test;

    localparam int CLK_PERIOD  = 10;
    localparam int REF_PERIOD  = 4;
    localparam int TIMEOUT_CYC = 2048;
    localparam int BPF         = 64;

    logic       mclk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       mclk_en = 1'b1;
    logic       lr_en = 1'b0;
    logic       pdn_n, mode_pin, mode_bit, conv_pwr, core_run;
    logic [1:0] ratio_sel;
    logic       lrclk_i = 1'b0;
    logic       bclk_o, bclk_oe, lrclk_o, lrclk_oe, conv_active;

    int  checks = 0;
    int  failures = 0;
    int  mcnt = 0;
    logic bclk_before = 1'b0;

    adc_port_clkctl #(.BCLK_PER_FRAME(BPF), .TIMEOUT_CYC(TIMEOUT_CYC)) uut (
        .mclk(mclk), .ref_clk(ref_clk), .pdn_n(pdn_n), .mode_pin(mode_pin),
        .mode_bit(mode_bit), .ratio_sel(ratio_sel), .conv_pwr(conv_pwr),
        .core_run(core_run), .lrclk_i(lrclk_i), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
        .lrclk_o(lrclk_o), .lrclk_oe(lrclk_oe), .conv_active(conv_active)
    );

    always begin
        #(CLK_PERIOD / 2);
        if (mclk_en) mclk = ~mclk;
        else         mclk = 1'b0;
    end

    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

    always begin
        #500;
        if (lr_en) lrclk_i = ~lrclk_i;
    end

    always @(posedge mclk) mcnt++;
    always @(negedge mclk) bclk_before = bclk_o;

    function automatic int exp_oe(input logic p, input logic pin, input logic b);
        return p ? int'(pin | b) : int'(pin);
    endfunction

    function automatic int exp_div(input logic [1:0] sel);
        int r;
        case (sel)
            2'b00:   r = 256;
            2'b01:   r = 384;
            2'b10:   r = 512;
            default: r = 768;
        endcase
        return r / BPF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_wait(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic meas_bclk(output int p);
        int a;
        @(posedge bclk_o); a = mcnt;
        @(posedge bclk_o); p = mcnt - a;
    endtask

    task automatic meas_lr(output int per, output int hi);
        int a, b;
        @(posedge lrclk_o); a = mcnt;
        @(negedge lrclk_o); b = mcnt;
        @(posedge lrclk_o); per = mcnt - a; hi = b - a;
    endtask

    task automatic settle_frames();
        repeat (2) @(lrclk_o);
    endtask

    task automatic check_oe(input string req);
        int e;
        e = exp_oe(pdn_n, mode_pin, mode_bit);
        check(bclk_oe == e[0] && lrclk_oe == e[0], req, int'(bclk_oe), e);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int p, hi, per;
        bit low_ok;
        pdn_n = 1'b0; mode_pin = 1'b0; mode_bit = 1'b0; ratio_sel = 2'b00;
        conv_pwr = 1'b0; core_run = 1'b0;
        void'($urandom(32'd7919));
        #23;

        // reset state
        check(!bclk_oe && !lrclk_oe, "R2 reset oe", int'(bclk_oe), 0);
        check(!conv_active, "R8 reset active", int'(conv_active), 0);
        mode_bit = 1'b1; #3;
        check(!bclk_oe && !lrclk_oe, "R2 bit ignored in power-down", int'(bclk_oe), 0);

        mode_pin = 1'b1; #1;
        check(bclk_oe && lrclk_oe, "R3 oe", int'(bclk_oe), 1);
        low_ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            #7;
            if (bclk_o || lrclk_o) low_ok = 1'b0;
        end
        check(low_ok, "R3 held low", int'(low_ok), 1);

        // R1 direction table with power up
        pdn_n = 1'b1; mode_pin = 1'b0; mode_bit = 1'b0; #3;
        check_oe("R1 slave");
        mode_bit = 1'b1; #3;
        check_oe("R1 bit master");
        mode_bit = 1'b0; mode_pin = 1'b1; #3;
        check_oe("R1 pin master");

        // R4 R5 R6 directed per ratio
        for (int s = 0; s < 4; s++) begin
            ratio_sel = 2'(s);
            settle_frames();
            meas_bclk(p);
            check(p == exp_div(2'(s)), "R4 bclk period", p, exp_div(2'(s)));
            meas_lr(per, hi);
            check(per == BPF * exp_div(2'(s)), "R5 lrclk period", per, BPF * exp_div(2'(s)));
            check(hi == (BPF / 2) * exp_div(2'(s)), "R5 lrclk high", hi, (BPF / 2) * exp_div(2'(s)));
            @(lrclk_o); #1;
            check(bclk_before && !bclk_o, "R6 lrclk on bclk fall", int'(bclk_o), 0);
        end

        // R7 ratio change mid-frame
        ratio_sel = 2'b00;
        settle_frames();
        @(posedge lrclk_o);
        repeat (3) @(posedge bclk_o);
        #1 ratio_sel = 2'b11;
        meas_bclk(p);
        check(p == 4, "R7 old ratio until frame edge", p, 4);
        @(lrclk_o);
        meas_bclk(p);
        check(p == 12, "R7 new ratio after frame edge", p, 12);

        // random direction table
        for (int i = 0; i < 30; i++) begin
            pdn_n = 1'($urandom % 2); mode_pin = 1'($urandom % 2); mode_bit = 1'($urandom % 2);
            #3;
            if (!pdn_n && !mode_pin)      check_oe("R2 random");
            else if (!pdn_n)              check_oe("R3 random");
            else                          check_oe("R1 random");
            if (!pdn_n && mode_pin)
                check(!bclk_o && !lrclk_o, "R3 random low", int'(bclk_o | lrclk_o), 0);
            #17;
        end

        // random ratios
        pdn_n = 1'b1; mode_pin = 1'b1; mode_bit = 1'b0;
        for (int i = 0; i < 3; i++) begin
            ratio_sel = 2'($urandom % 4);
            settle_frames();
            meas_bclk(p);
            check(p == exp_div(ratio_sel), "R4 random ratio", p, exp_div(ratio_sel));
        end

        // converter active in master mode
        ref_wait(2);
        conv_pwr = 1'b1; core_run = 1'b1;
        ref_wait(50);
        check(conv_active, "R9 master active", int'(conv_active), 1);
        conv_pwr = 1'b0; ref_wait(2);
        check(!conv_active, "R8 power bit off", int'(conv_active), 0);
        conv_pwr = 1'b1; ref_wait(50);
        check(conv_active, "R9 power restored", int'(conv_active), 1);
        core_run = 1'b0; ref_wait(2);
        check(!conv_active, "R8 run bit off", int'(conv_active), 0);
        core_run = 1'b1; ref_wait(50);
        check(conv_active, "R9 run restored", int'(conv_active), 1);

        // R11 master clock timeout boundary
        mclk_en = 1'b0;
        ref_wait(TIMEOUT_CYC - 200);
        check(conv_active, "R11 before timeout", int'(conv_active), 1);
        ref_wait(400);
        check(!conv_active, "R11 after timeout", int'(conv_active), 0);
        mclk_en = 1'b1; ref_wait(50);
        check(conv_active, "R9 mclk restored", int'(conv_active), 1);

        // R10 slave needs frame clock
        mode_pin = 1'b0; mode_bit = 1'b0;
        ref_wait(100);
        check(!conv_active, "R10 slave without frame", int'(conv_active), 0);
        lr_en = 1'b1;
        ref_wait(500);
        check(conv_active, "R10 slave with frame", int'(conv_active), 1);
        lr_en = 1'b0;
        ref_wait(TIMEOUT_CYC + 400);
        check(!conv_active, "R11 frame lost", int'(conv_active), 0);

        pdn_n = 1'b0; #1;
        check(!conv_active, "R8 power-down", int'(conv_active), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule